// File: doc/BRIEF.md
# Hardwired Accumulator Processor Controller

This block is a small 8-bit accumulator processor. Its control unit is built from fixed logic, one decode term for each control column. Each instruction byte holds a 4-bit opcode in the upper nibble and a 4-bit memory address in the lower nibble. A state machine first runs one fetch step that is shared by every instruction, and then runs the execute step or steps for the fetched opcode. The block contains a 16-byte RAM, a program counter, an instruction register, an accumulator, a B operand register, an 8-bit adder and one shared data bus. Three sources can drive that bus: memory, the accumulator and the adder.

The states are `ST_FETCH`, `ST_EXEC`, `ST_ADD2` and `ST_STOP`, and the state machine moves between them as follows:

- **FETCH→EXEC:** always taken.
- **EXEC→FETCH:** taken for LOAD and STORE.
- **EXEC→ADD2:** taken for ADD.
- **EXEC→STOP:** taken for HALT and for any undefined opcode.
- **ADD2→FETCH:** always taken.
- **STOP→STOP:** the machine holds here until reset.

While reset is held, the bench fills the RAM through a load port. A second, combinational read port lets the RAM be read back at any time. The `ctl` output shows the seven datapath control lines for every step.

Top module: `acc_cpu`

## Requirements
- R1: Fetch and the program counter. In every fetch step, `ctl` equals 0x01: only memory read is set. The instruction byte at address `pc_q` is captured, and `pc_q` increments by one, wrapping modulo 16. The `ctl` bits are: bit0 memory read, bit1 memory write, bit2 B load, bit3 ALU add, bit4 accumulator load, bit5 accumulator bus drive, bit6 halt.
- R2: Operand address. LOAD, ADD and STORE use instruction bits [3:0] as the memory address. This holds for address 15 as well.
- R3: LOAD (opcode 0). LOAD takes one execute step, in which `ctl` is 0x11. The addressed byte goes straight into the accumulator.
- R4: ADD (opcode 1). The first execute step has `ctl` 0x05 and loads B from memory. The next step has `ctl` 0x18 and loads the accumulator with accumulator + B, modulo 256.
- R5: STORE (opcode 2). STORE takes one execute step, in which `ctl` is 0x22. The accumulator is written to the addressed byte.
- R6: HALT (opcode 3). HALT takes one execute step, in which `ctl` is 0x40. After that step, `halted` is 1, `ctl` is 0x00 and `pc_q` is frozen, and all three stay that way until reset.
- R7: Undefined opcodes (4 to 15) behave exactly like HALT. They do not change memory.
- R8: In every step, at most one of memory read, ALU add and accumulator drive is 1. Memory read and memory write are never 1 together.
- R9: Synchronous active-high reset. After a reset cycle, `pc_q` is 0, `acc_q` is 0 and `halted` is 0. The next step is a fetch.
- R10: While `rst` is 1, a write with `ld_we` stores `ld_data` at `ld_addr`. `rd_data` always shows the RAM byte at `rd_addr`, and the RAM contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| ld_we | input | 1 | Load-port write enable (only acted on during reset) |
| ld_addr | input | 4 | Load-port address |
| ld_data | input | 8 | Load-port data |
| rd_addr | input | 4 | Read-back address |
| rd_data | output | 8 | RAM byte at `rd_addr` |
| acc_q | output | 8 | Accumulator |
| pc_q | output | 4 | Program counter |
| ctl | output | 7 | Control lines of the current step |
| halted | output | 1 | High once a halting opcode has executed |

## Verification
A wrong state or a wrong decode term shows up on `ctl` in the same cycle, because `ctl` is decoded combinationally from the state register and the instruction register. The bench therefore compares `ctl` against the expected step sequence on every cycle of a full program. A fault in the accumulator, the B register or the adder shows on `acc_q` in the cycle that follows the step that loads it. A wrong bus source or a wrong address shows in the RAM read-back once the program halts. A missing halt or a halt that does not hold shows as `pc_q` moving, or `halted` dropping, within one cycle.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_ADD2  = 2'd2,
        ST_STOP  = 2'd3
    } step_e;

    typedef enum logic [3:0] {
        OP_LOAD  = 4'd0,
        OP_ADD   = 4'd1,
        OP_STORE = 4'd2,
        OP_HALT  = 4'd3
    } opcode_e;

    // Bit order matches the ctl port: bit0 mem_rd ... bit6 halt.
    typedef struct packed {
        logic halt;
        logic acc_drv;
        logic acc_ld;
        logic alu_add;
        logic b_ld;
        logic mem_wr;
        logic mem_rd;
    } ctl_t;

    localparam int CTL_W = 7;

endpackage

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] opcode,
    output step_e      step,
    output ctl_t       ctl,
    output logic       ir_ld,
    output logic       pc_inc
);

    step_e step_nx;
    logic  known_op;

    // Opcodes outside the four defined ones decode as HALT.
    always_comb begin
        known_op = (opcode == OP_LOAD) || (opcode == OP_ADD) || (opcode == OP_STORE);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_FETCH;
        end else begin
            step <= step_nx;
        end
    end

    // Next-state logic.
    always_comb begin
        step_nx = step;
        unique case (step)
            ST_FETCH: step_nx = ST_EXEC;
            ST_EXEC: begin
                if (!known_op)            step_nx = ST_STOP;
                else if (opcode == OP_ADD) step_nx = ST_ADD2;
                else                      step_nx = ST_FETCH;
            end
            ST_ADD2: step_nx = ST_FETCH;
            ST_STOP: step_nx = ST_STOP;
            default: step_nx = ST_FETCH;
        endcase
    end

    // Output decode: each line is an OR of step-and-opcode terms.
    always_comb begin
        ctl    = '0;
        ir_ld  = 1'b0;
        pc_inc = 1'b0;
        unique case (step)
            ST_FETCH: begin
                ctl.mem_rd = 1'b1;
                ir_ld      = 1'b1;
                pc_inc     = 1'b1;
            end
            ST_EXEC: begin
                if (!known_op) begin
                    ctl.halt = 1'b1;
                end else begin
                    unique case (opcode)
                        OP_LOAD: begin
                            ctl.mem_rd = 1'b1;
                            ctl.acc_ld = 1'b1;
                        end
                        OP_ADD: begin
                            ctl.mem_rd = 1'b1;
                            ctl.b_ld   = 1'b1;
                        end
                        OP_STORE: begin
                            ctl.acc_drv = 1'b1;
                            ctl.mem_wr  = 1'b1;
                        end
                        default: ctl.halt = 1'b1;
                    endcase
                end
            end
            ST_ADD2: begin
                ctl.alu_add = 1'b1;
                ctl.acc_ld  = 1'b1;
            end
            ST_STOP: ctl = '0;
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/acc_ram.sv
module acc_ram #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  step_e         step,
    input  ctl_t          ctl,
    input  logic          ir_ld,
    input  logic          pc_inc,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] bus,
    output logic [DW-AW-1:0] opcode,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] pc
);

    logic [DW-1:0] ir;
    logic [DW-1:0] breg;
    logic [DW-1:0] sum;

    assign opcode   = ir[DW-1:AW];
    assign mem_addr = (step == ST_FETCH) ? pc : ir[AW-1:0];
    assign sum      = acc + breg;

    // Single shared bus: exactly one source is selected by its driver line.
    always_comb begin
        bus = '0;
        if (ctl.mem_rd)       bus = mem_rdata;
        else if (ctl.alu_add) bus = sum;
        else if (ctl.acc_drv) bus = acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= '0;
            acc  <= '0;
            breg <= '0;
            ir   <= '0;
        end else begin
            if (pc_inc)     pc   <= pc + 1'b1;
            if (ir_ld)      ir   <= bus;
            if (ctl.b_ld)   breg <= bus;
            if (ctl.acc_ld) acc  <= bus;
        end
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] acc_q,
    output logic [AW-1:0] pc_q,
    output logic [CTL_W-1:0] ctl,
    output logic          halted
);

    step_e            step;
    ctl_t             ctl_s;
    logic             ir_ld;
    logic             pc_inc;
    logic [AW-1:0]    mem_addr;
    logic [DW-1:0]    mem_rdata;
    logic [DW-1:0]    bus;
    logic [DW-AW-1:0] opcode;
    logic             ram_we;
    logic [AW-1:0]    ram_waddr;
    logic [DW-1:0]    ram_wdata;

    acc_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode[3:0]),
        .step   (step),
        .ctl    (ctl_s),
        .ir_ld  (ir_ld),
        .pc_inc (pc_inc)
    );

    acc_datapath #(.DW(DW), .AW(AW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .ctl       (ctl_s),
        .ir_ld     (ir_ld),
        .pc_inc    (pc_inc),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .bus       (bus),
        .opcode    (opcode),
        .acc       (acc_q),
        .pc        (pc_q)
    );

    // Load port owns the write side while reset is held.
    assign ram_we    = rst ? ld_we   : ctl_s.mem_wr;
    assign ram_waddr = rst ? ld_addr : mem_addr;
    assign ram_wdata = rst ? ld_data : bus;

    acc_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr_a (mem_addr),
        .rdata_a (mem_rdata),
        .raddr_b (rd_addr),
        .rdata_b (rd_data)
    );

    assign ctl    = ctl_s;
    assign halted = (step == ST_STOP);

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [6:0]    ctl,
    input logic [AW-1:0] pc_q,
    input logic          halted
);

    a_r8_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl[0], ctl[3], ctl[5]}));

    a_r8_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(ctl[0] && ctl[1]));

    a_r4_add_second_step: assert property (@(posedge clk) disable iff (rst)
        (ctl == 7'h05) |=> (ctl == 7'h18));

    a_r3_load_returns: assert property (@(posedge clk) disable iff (rst)
        (ctl == 7'h11) |=> (ctl == 7'h01));

    a_r6_halt_enters_stop: assert property (@(posedge clk) disable iff (rst)
        ctl[6] |=> halted);

    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc_q) && ctl == 7'h00));

endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .pc_q   (pc_q),
    .halted (halted)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_we = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] acc_q;
    logic [3:0] pc_q;
    logic [6:0] ctl;
    logic       halted;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    acc_cpu uut (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .acc_q(acc_q), .pc_q(pc_q),
        .ctl(ctl), .halted(halted)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Hold reset and write one RAM byte through the load port.
    task automatic poke(input logic [3:0] a, input logic [7:0] d);
        rst = 1'b1; ld_we = 1'b1; ld_addr = a; ld_data = d;
        tick();
        ld_we = 1'b0;
    endtask

    task automatic fill(input logic [7:0] d);
        for (int i = 0; i < 16; i++) poke(4'(i), d);
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic run_to_halt();
        rst = 1'b0;
        for (int i = 0; i < 40 && !halted; i++) tick();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick();
        check("R9 pc after reset", pc_q, 0);
        check("R9 acc after reset", acc_q, 0);
        check("R9 halted after reset", halted, 0);
    endtask

    task automatic t_main_program();
        logic [7:0] d;
        logic [6:0] exp_seq [10];
        string      tag_seq [10];
        exp_seq = '{7'h01, 7'h11, 7'h01, 7'h05, 7'h18, 7'h01, 7'h22, 7'h01, 7'h40, 7'h00};
        tag_seq = '{"R1 fetch", "R3 load", "R1 fetch", "R4 add step1", "R4 add step2",
                    "R1 fetch", "R5 store", "R1 fetch", "R6 halt", "R6 stopped"};
        fill(8'h00);
        poke(4'h0, 8'h0A);
        poke(4'h1, 8'h1B);
        poke(4'h2, 8'h2C);
        poke(4'h3, 8'h30);
        poke(4'hA, 8'h05);
        poke(4'hB, 8'hFE);
        peek(4'hB, d);
        check("R10 load port readback", d, 8'hFE);
        rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            check(tag_seq[i], ctl, exp_seq[i]);
            if (i == 2) check("R3 acc after load", acc_q, 8'h05);
            if (i == 5) check("R4 acc wraps mod 256", acc_q, 8'h03);
            tick();
        end
        check("R6 halted", halted, 1);
        check("R1 pc counts fetches", pc_q, 4'h4);
        peek(4'hC, d);
        check("R5 stored byte", d, 8'h03);
        peek(4'hB, d);
        check("R2 operand untouched", d, 8'hFE);
    endtask

    task automatic t_hold_after_halt();
        logic [3:0] p;
        p = pc_q;
        for (int i = 0; i < 5; i++) tick();
        check("R6 halted holds", halted, 1);
        check("R6 pc frozen", pc_q, p);
        check("R6 ctl idle", ctl, 0);
    endtask

    task automatic t_undefined_opcode();
        logic [7:0] d;
        fill(8'hAA);
        poke(4'h0, 8'h05);
        poke(4'h1, 8'h9A);
        poke(4'h5, 8'h77);
        rst = 1'b0;
        tick(); tick(); tick();
        check("R7 undefined decodes as halt", ctl, 7'h40);
        tick();
        check("R7 halted", halted, 1);
        check("R7 pc", pc_q, 4'h2);
        check("R7 acc", acc_q, 8'h77);
        peek(4'hA, d);
        check("R7 memory untouched", d, 8'hAA);
    endtask

    task automatic t_top_address();
        logic [7:0] d;
        fill(8'h00);
        poke(4'h0, 8'h0F);
        poke(4'h1, 8'h1F);
        poke(4'h2, 8'h20);
        poke(4'h3, 8'h30);
        poke(4'hF, 8'h80);
        run_to_halt();
        check("R2 address 15 halted", halted, 1);
        check("R4 0x80+0x80 wraps", acc_q, 8'h00);
        peek(4'h0, d);
        check("R5 store to address 0", d, 8'h00);
        peek(4'hF, d);
        check("R2 address 15 value", d, 8'h80);
    endtask

    task automatic t_reset_after_run();
        logic [7:0] d;
        fill(8'h00);
        poke(4'h0, 8'h03);
        poke(4'h1, 8'h30);
        poke(4'h3, 8'h42);
        run_to_halt();
        check("R3 acc before reset", acc_q, 8'h42);
        rst = 1'b1;
        tick();
        check("R9 acc cleared", acc_q, 0);
        check("R9 pc cleared", pc_q, 0);
        check("R9 halted cleared", halted, 0);
        peek(4'h3, d);
        check("R10 RAM survives reset", d, 8'h42);
        rst = 1'b0;
        check("R9 first step is fetch", ctl, 7'h01);
        tick();
        check("R3 load after reset", ctl, 7'h11);
        rst = 1'b1;
        tick();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_main_program();
        t_hold_after_halt();
        t_undefined_opcode();
        t_top_address();
        t_reset_after_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule